// File: doc/BRIEF.md
# Mobile SDRAM Command State Tracker

This block watches the command pins of a four-bank mobile SDRAM on every rising clock edge and keeps track of the command-level state the device is in. It shows that state, which banks currently hold an open row, and whether the command just seen breaks the rules. Memory contents, data timing and electrical effects are not modelled. It is meant to sit beside a memory controller, as a protocol monitor or as the state core of a behavioural device model.

The tracker covers the usual flow: idle, activate, read and write bursts of a fixed length, and precharge of one bank or of all banks. It also covers the mobile extras: an extended mode register, self refresh and deep power-down entered with the clock enable low, and the power-down and suspend states that a low clock enable causes. A column command with the auto-precharge bit set closes its bank by itself when the burst finishes.

Top module: `sdram_state_tracker`

## Requirements
- R1: While `rst_n` is low, `dev_state` is 0 (idle), `bank_open` is all zero and `illegal` is 0.
- R2: A command is taken only at an edge where `cs_n` is low and `cke` is high. It is decoded from {`ras_n`,`cas_n`,`we_n`]: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop, 111 no-op. With `cs_n` high the edge acts as a no-op.
- R3: Activate sets `bank_open[ba]` and moves idle (0) to row active (6). Activate on a bank that is already open is illegal.
- R4: Precharge with `a10`=1 closes every bank. With `a10`=0 it closes bank `ba` only, and a closed bank is left unchanged. When no bank stays open, the state becomes idle (0).
- R5: Read or write on an open bank shows state 7 (read) or 8 (write) for exactly BURST_LEN edges. After that the state is 6 if a bank is open and 0 if none is. A column command on a closed bank is illegal.
- R6: A column command with `a10`=1 closes its bank when the burst ends. A new column command while such a burst is running is illegal.
- R7: A burst stop during a burst ends it at that edge, so the state becomes 6 or 0. Outside a burst it has no effect.
- R8: Refresh and mode-register set are legal only in idle. Mode-register set gives state 1 when the top bank bit is 0 and state 2 (extended) when it is 1. Refresh gives state 3. Each of these lasts one cycle and then returns to idle. Any command other than a no-op during that cycle is illegal.
- R9: `illegal` is 1 for exactly the cycle after the edge that took an illegal command. That command changes neither the state nor `bank_open`. Precharge during a burst is illegal.
- R10: An edge with `cke` low and no low-power entry command moves the state as follows: idle to 11, active to 12, read to 9, write to 10. Commands are ignored while `cke` is low. The next edge with `cke` high restores 0, 6, 7 or 8. That resume edge does not advance the burst.
- R11: From idle, refresh with `cke` low enters self refresh (4), and burst stop with `cke` low enters deep power-down (5). The first edge with `cke` high leaves either state to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command bit 2 |
| cas_n | input | 1 | Column strobe, command bit 1 |
| we_n | input | 1 | Write enable, command bit 0 |
| ba | input | BANK_BITS | Bank select |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| dev_state | output | 4 | Current device state code |
| bank_open | output | 2**BANK_BITS | One bit per bank, set while a row is open |
| illegal | output | 1 | Previous edge took an illegal command |

## Verification
The hardest case to reach is a write burst frozen in suspend. It needs an open bank, a write already partly done, a falling clock enable in the middle of the burst, and a command issued while frozen that must leave no trace. The bench builds this with activate, write and a no-op, then holds `cke` low for several edges while it issues a precharge-all. It then counts the write cycles left after resume against the number the burst length predicts. Full sweeps of every command, bank and auto-precharge value, run from both idle and one-bank-active, cover the legality rules.

// File: rtl/sdram_state_tracker.sv
module sdram_state_tracker #(
  parameter int BURST_LEN = 4,
  parameter int BANK_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [BANK_BITS-1:0]        ba,
  input  logic                        a10,
  output logic [3:0]                  dev_state,
  output logic [(1<<BANK_BITS)-1:0]   bank_open,
  output logic                        illegal
);
  localparam int NB = 1 << BANK_BITS;
  localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
  localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_MRS = 4'd1, S_EMRS = 4'd2, S_AREF = 4'd3,
    S_SREF = 4'd4, S_DPD = 4'd5, S_ACT = 4'd6, S_RD = 4'd7,
    S_WR = 4'd8, S_RDS = 4'd9, S_WRS = 4'd10, S_IPD = 4'd11, S_APD = 4'd12
  } st_t;

  st_t                  st, st_n;
  logic [NB-1:0]        open_n;
  logic [CW-1:0]        cnt, cnt_n;
  logic                 ap, ap_n;
  logic [BANK_BITS-1:0] bb, bb_n;
  logic                 bad, take, start, end_burst;

  wire [2:0] cmd       = {ras_n, cas_n, we_n};
  wire       sel       = !cs_n;
  wire       bursting  = (st == S_RD) || (st == S_WR);
  wire       normal    = (st == S_IDLE) || (st == S_ACT) || bursting;
  wire       transient = (st == S_MRS) || (st == S_EMRS) || (st == S_AREF);

  always_comb begin
    bad = 1'b0;
    if (cke && sel) begin
      if (transient)
        bad = (cmd != C_NOP);
      else if (normal)
        case (cmd)
          C_ACT:       bad = bank_open[ba];
          C_RD, C_WR:  bad = !bank_open[ba] || (bursting && ap);
          C_PRE:       bad = bursting;
          C_REF, C_MRS: bad = (st != S_IDLE);
          default:     bad = 1'b0;
        endcase
    end
  end

  assign take = cke && sel && normal && !bad;

  always_comb begin
    st_n      = st;
    open_n    = bank_open;
    cnt_n     = cnt;
    ap_n      = ap;
    bb_n      = bb;
    start     = 1'b0;
    end_burst = 1'b0;
    case (st)
      S_IDLE, S_ACT, S_RD, S_WR: begin
        if (!cke) begin
          if (st == S_IDLE && sel && cmd == C_REF)      st_n = S_SREF;
          else if (st == S_IDLE && sel && cmd == C_BST) st_n = S_DPD;
          else if (st == S_IDLE)                        st_n = S_IPD;
          else if (st == S_ACT)                         st_n = S_APD;
          else if (st == S_RD)                          st_n = S_RDS;
          else                                          st_n = S_WRS;
        end else begin
          if (bursting) begin
            if (cnt == '0) end_burst = 1'b1;
            else           cnt_n = cnt - CW'(1);
          end
          if (take)
            case (cmd)
              C_ACT:      open_n[ba] = 1'b1;
              C_RD, C_WR: start = 1'b1;
              C_PRE:      if (a10) open_n = '0; else open_n[ba] = 1'b0;
              C_BST:      if (bursting) end_burst = 1'b1;
              default:    ;
            endcase
          if (start) begin
            st_n  = (cmd == C_RD) ? S_RD : S_WR;
            cnt_n = CW'(BURST_LEN - 1);
            ap_n  = a10;
            bb_n  = ba;
          end else if (end_burst) begin
            if (ap) open_n[bb] = 1'b0;
            ap_n = 1'b0;
            st_n = (|open_n) ? S_ACT : S_IDLE;
          end else if (take && cmd == C_REF) begin
            st_n = S_AREF;
          end else if (take && cmd == C_MRS) begin
            st_n = ba[BANK_BITS-1] ? S_EMRS : S_MRS;
          end else if (!bursting) begin
            st_n = (|open_n) ? S_ACT : S_IDLE;
          end
        end
      end
      S_MRS, S_EMRS, S_AREF:  st_n = S_IDLE;
      S_SREF, S_DPD, S_IPD:   if (cke) st_n = S_IDLE;
      S_APD:                  if (cke) st_n = S_ACT;
      S_RDS:                  if (cke) st_n = S_RD;
      S_WRS:                  if (cke) st_n = S_WR;
      default:                st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bank_open <= '0;
      cnt       <= '0;
      ap        <= 1'b0;
      bb        <= '0;
      illegal   <= 1'b0;
    end else begin
      st        <= st_n;
      bank_open <= open_n;
      cnt       <= cnt_n;
      ap        <= ap_n;
      bb        <= bb_n;
      illegal   <= bad;
    end
  end

  assign dev_state = st;

  assert_idle_no_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> bank_open == '0);
  assert_dpd_no_rows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DPD |-> bank_open == '0);
  assert_sref_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SREF && cke) |=> st == S_IDLE);
  assert_wsusp_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRS && cke) |=> st == S_WR);
  assert_suspend_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRS && !cke) |=> (st == S_WRS && $stable(bank_open)));
  assert_transient_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MRS || st == S_EMRS || st == S_AREF) |=> st == S_IDLE);
  assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cke && cs_n) |=> st == S_IDLE);
  assert_illegal_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !$past(bursting)) |-> bank_open == $past(bank_open));
endmodule

// File: tb/test_sdram_state_tracker.sv
module test_sdram_state_tracker;
  localparam int BL = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       a10 = 1'b0;
  logic [3:0] dev_state;
  logic [3:0] bank_open;
  logic       illegal;
  int         vec = 0, bad = 0;
  bit         done = 0;

  sdram_state_tracker #(.BURST_LEN(BL), .BANK_BITS(2)) i_sdram_state_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .dev_state(dev_state), .bank_open(bank_open),
    .illegal(illegal));

  always #4 clk = ~clk;

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011;
  localparam logic [2:0] WR = 3'b100, RD = 3'b101, BST = 3'b110, NOP = 3'b111;

  task automatic chk(input string r, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk3(input string r, input int s, input int b, input int il);
    chk({r, " state"}, int'(dev_state), s);
    chk({r, " banks"}, int'(bank_open), b);
    chk({r, " illegal"}, int'(illegal), il);
  endtask

  task automatic cyc(input logic k, input logic c, input logic [2:0] cm,
                     input logic [1:0] b, input logic a);
    @(negedge clk);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = cm; ba = b; a10 = a;
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] cm, input logic [1:0] b, input logic a);
    cyc(1'b1, 1'b0, cm, b, a);
  endtask

  task automatic nop();
    cyc(1'b1, 1'b1, NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = NOP; ba = '0; a10 = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int es, eb, ei, n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk3("R1 reset", 0, 0, 0);
    rst_n = 1'b1;

    // R2 R3 R8: every command from idle, selected and deselected
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++) begin
            do_reset();
            cyc(1'b1, s[0], c[2:0], b[1:0], a[0]);
            es = 0; eb = 0; ei = 0;
            if (s == 0)
              case (c[2:0])
                ACT: begin es = 6; eb = 1 << b; end
                RD, WR: ei = 1;
                MRS: es = (b >= 2) ? 2 : 1;
                REF: es = 3;
                default: ;
              endcase
            chk3("R2 R3 R8 idle sweep", es, eb, ei);
            if (es == 1 || es == 2 || es == 3) begin
              nop();
              chk("R8 back to idle", int'(dev_state), 0);
            end
          end

    // R3 R4 R5 R9: every command with bank 2 open
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 2; a++) begin
          do_reset();
          cmd(ACT, 2'd2, 1'b0);
          cmd(c[2:0], b[1:0], a[0]);
          es = 6; eb = 4; ei = 0;
          case (c[2:0])
            ACT: if (b == 2) ei = 1; else eb = 4 | (1 << b);
            RD:  if (b == 2) es = 7; else ei = 1;
            WR:  if (b == 2) es = 8; else ei = 1;
            PRE: if (a == 1 || b == 2) begin es = 0; eb = 0; end
            REF, MRS: ei = 1;
            default: ;
          endcase
          chk3("R3 R4 R5 R9 active sweep", es, eb, ei);
        end

    // R5 R6: burst length and auto-precharge
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 2; a++) begin
        do_reset();
        cmd(ACT, 2'd1, 1'b0);
        cmd(w ? WR : RD, 2'd1, a[0]);
        n = 0;
        while ((dev_state == 7 || dev_state == 8) && n < 20) begin
          n++;
          nop();
        end
        chk("R5 burst length", n, BL);
        chk("R6 end state", int'(dev_state), a ? 0 : 6);
        chk("R6 end banks", int'(bank_open), a ? 0 : 2);
      end

    // R10: write suspend with an ignored command
    do_reset();
    cmd(ACT, 2'd0, 1'b0);
    cmd(WR, 2'd0, 1'b0);
    nop();
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, PRE, 2'd0, 1'b1);
      chk3("R10 write suspend", 10, 1, 0);
    end
    nop();
    chk("R10 write resume", int'(dev_state), 8);
    n = 0;
    while (dev_state == 8 && n < 20) begin
      n++;
      nop();
    end
    chk("R10 beats after resume", n, BL - 1);
    chk3("R10 after write", 6, 1, 0);

    // R10: read suspend
    cmd(RD, 2'd0, 1'b0);
    cyc(1'b0, 1'b1, NOP, 2'd0, 1'b0);
    chk("R10 read suspend", int'(dev_state), 9);
    nop();
    chk("R10 read resume", int'(dev_state), 7);

    // R10: idle and active power-down
    do_reset();
    cyc(1'b0, 1'b1, NOP, 2'd0, 1'b0);
    chk("R10 idle power-down", int'(dev_state), 11);
    cyc(1'b0, 1'b0, ACT, 2'd1, 1'b0);
    chk3("R10 ignored activate", 11, 0, 0);
    nop();
    chk("R10 power-down exit", int'(dev_state), 0);
    cmd(ACT, 2'd3, 1'b0);
    cyc(1'b0, 1'b0, REF, 2'd0, 1'b0);
    chk3("R10 R11 active power-down", 12, 8, 0);
    nop();
    chk3("R10 active power-down exit", 6, 8, 0);

    // R11: self refresh and deep power-down
    do_reset();
    cyc(1'b0, 1'b0, REF, 2'd0, 1'b0);
    chk("R11 self refresh entry", int'(dev_state), 4);
    cyc(1'b0, 1'b1, NOP, 2'd0, 1'b0);
    chk("R11 self refresh hold", int'(dev_state), 4);
    nop();
    chk("R11 self refresh exit", int'(dev_state), 0);
    cyc(1'b0, 1'b0, BST, 2'd0, 1'b0);
    chk("R11 deep power-down entry", int'(dev_state), 5);
    nop();
    chk3("R11 deep power-down exit", 0, 0, 0);

    // R7: burst stop
    do_reset();
    cmd(ACT, 2'd0, 1'b0);
    cmd(BST, 2'd0, 1'b0);
    chk3("R7 stop outside burst", 6, 1, 0);
    cmd(RD, 2'd0, 1'b0);
    cmd(BST, 2'd0, 1'b0);
    chk3("R7 stop inside burst", 6, 1, 0);

    // R9: precharge during burst, flag lasts one cycle
    cmd(RD, 2'd0, 1'b0);
    cmd(PRE, 2'd0, 1'b1);
    chk3("R9 precharge in burst", 7, 1, 1);
    nop();
    chk("R9 flag clears", int'(illegal), 0);

    // R6: column command during auto-precharge burst
    do_reset();
    cmd(ACT, 2'd0, 1'b0);
    cmd(ACT, 2'd1, 1'b0);
    cmd(RD, 2'd0, 1'b1);
    cmd(RD, 2'd1, 1'b0);
    chk3("R6 column during auto-precharge", 7, 3, 1);

    // R8: command during mode-register cycle
    do_reset();
    cmd(MRS, 2'd0, 1'b0);
    cmd(ACT, 2'd1, 1'b0);
    chk3("R8 command in mode-register cycle", 0, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule